// File: doc/BRIEF.md
# Multiplexer-Selected Unsigned Array Multiplier

This block multiplies two unsigned operands of `W` bits each (16 by default) and returns the full `2W`-bit product. It does not build a full AND-gate partial-product matrix. It splits the product into one row per operand bit position `j`, and each row carries a single selected term. The term for row `j` depends on the bit pair `(a[j], b[j])`:

- when neither bit is set, the term is zero;
- when only one bit is set, the term is the other operand's lower `j` bits;
- when both bits are set, the term is the running sum of both operands' lower `j` bits.

That running sum is built once by a bit-serial carry chain and shared by all rows. In addition, the diagonal bits `a[j]&b[j]` are placed at weight `2^(2j)`.

The rows and the diagonal vector are compressed by a carry-save array. The two vectors that remain are then resolved by an adder made of 2-bit carry-lookahead groups.

An optional output register is chosen by the parameter `REG_OUT`:

- With `REG_OUT` = 1 (the default), the product appears one clock after the operands. A synchronous active-high reset clears it to zero.
- With `REG_OUT` = 0, the block is purely combinational.

Top module: `pairsel_mult`

## Requirements
- R1: For all unsigned operand values, the product equals `a_i * b_i` over the full `2W` bits, with no truncation. The bench covers this exhaustively over all 8-bit operand pairs and on random 16-bit pairs.
- R2: The running sum of the lower operand bits, formed one bit per position, equals `a_i + b_i` including the final carry. Products whose operands generate long carry runs are correct, for example all-ones with one, and alternating `0x5555` with `0xAAAA`.
- R3: Row `j` (j ≥ 1) adds a term at weight `2^j`, chosen by select `{a[j], b[j]}`:
  - 00 gives zero;
  - 01 gives the lower `j` bits of `a_i`;
  - 10 gives the lower `j` bits of `b_i`;
  - 11 gives their sum.

  This row term is added together with the diagonal bit `a[j]&b[j]` at weight `2^(2j)`.
- R4: Row 0 has no lower bits, so it contributes only `a[0]&b[0]` at weight 1. For example, 1×1 = 1 and 1×0xFFFF = 0xFFFF.
- R5: Swapping the operands gives the same product.
- R6: With `REG_OUT` = 1, `prod_o` reflects the operands sampled at the previous rising clock edge. The output stays unchanged until that edge.
- R7: A synchronous active-high `rst` forces `prod_o` to zero at the next rising edge, whatever the operands are.
- R8: For 4-bit values, 7 × 3 gives 21. For both operands all-ones, the product is `(2^W-1)^2`, which is 0xFFFE0001 for W = 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_i | input | W | First unsigned operand |
| b_i | input | W | Second unsigned operand |
| prod_o | output | 2W | Unsigned product |

## Verification
Every cycle, the assertions check three internal results against the current operands:

- the shared running-sum chain against an arithmetic sum;
- each multiplexer row term against its arithmetic form;
- the combinational product against a reference multiply.

The assertions also check the one-cycle output latency and the reset clearing the output. Operand symmetry, the row-0 special case, and the exhaustive 8-bit sweep can only be shown by the bench's scenarios. The same holds for the carry-heavy and all-ones corners, and for the output holding steady before the clock edge.

// File: rtl/pairsel_pkg.sv
package pairsel_pkg;

    // Row selector formed as {a[j], b[j]}
    typedef enum logic [1:0] {
        PICK_ZERO = 2'b00,
        PICK_A    = 2'b01,
        PICK_B    = 2'b10,
        PICK_SUM  = 2'b11
    } pick_e;

    localparam int DEF_WIDTH = 16;

endpackage

// File: rtl/pairsel_sumchain.sv
module pairsel_sumchain #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic [W:1]   carry_o
);
    // Bit-serial running sum: position j uses the carry produced below it
    always_comb begin
        logic cy;
        cy = 1'b0;
        for (int j = 0; j < W; j++) begin
            sum_o[j]     = a_i[j] ^ b_i[j] ^ cy;
            cy           = (a_i[j] & b_i[j]) | (cy & (a_i[j] ^ b_i[j]));
            carry_o[j+1] = cy;
        end
    end
endmodule

// File: rtl/pairsel_rowgen.sv
module pairsel_rowgen
    import pairsel_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]            a_i,
    input  logic [W-1:0]            b_i,
    input  logic [W-2:0]            sum_i,
    input  logic [W-1:1]            carry_i,
    output logic [W-1:0][2*W-1:0]   rows_o,
    output logic [2*W-1:0]          diag_o
);
    localparam int PW = 2 * W;

    for (genvar j = 0; j < W; j++) begin : g_row
        assign diag_o[2*j]   = a_i[j] & b_i[j];
        assign diag_o[2*j+1] = 1'b0;

        if (j == 0) begin : g_first
            assign rows_o[j] = '0;
        end else begin : g_rest
            logic [j:0] low_a;
            logic [j:0] low_b;
            logic [j:0] low_s;
            logic [j:0] term;
            pick_e      pick;

            assign low_a = {1'b0, a_i[j-1:0]};
            assign low_b = {1'b0, b_i[j-1:0]};
            assign low_s = {carry_i[j], sum_i[j-1:0]};
            assign pick  = pick_e'({a_i[j], b_i[j]});

            always_comb begin
                unique case (pick)
                    PICK_ZERO: term = '0;
                    PICK_A:    term = low_a;
                    PICK_B:    term = low_b;
                    PICK_SUM:  term = low_s;
                    default:   term = '0;
                endcase
            end

            assign rows_o[j] = PW'(term) << j;
        end
    end
endmodule

// File: rtl/pairsel_accum.sv
module pairsel_accum #(
    parameter int W = 16
) (
    input  logic [W-1:0][2*W-1:0] rows_i,
    input  logic [2*W-1:0]        diag_i,
    output logic [2*W-1:0]        prod_o
);
    localparam int PW     = 2 * W;
    localparam int GROUPS = PW / 2;

    logic [PW-1:0] red_s;
    logic [PW-1:0] red_c;

    // Carry-save compression of every row into two vectors
    always_comb begin
        logic [PW-1:0] ps;
        logic [PW-1:0] pc;
        logic [PW-1:0] t;
        ps = diag_i;
        pc = '0;
        for (int j = 1; j < W; j++) begin
            t  = rows_i[j];
            {ps, pc} = {ps ^ pc ^ t, ((ps & pc) | (ps & t) | (pc & t)) << 1};
        end
        red_s = ps;
        red_c = pc;
    end

    // Carry-propagate adder made of 2-bit lookahead groups
    always_comb begin
        logic cy;
        logic g0, g1, p0, p1, c1;
        cy = 1'b0;
        prod_o = '0;
        for (int k = 0; k < GROUPS; k++) begin
            g0 = red_s[2*k]   & red_c[2*k];
            p0 = red_s[2*k]   ^ red_c[2*k];
            g1 = red_s[2*k+1] & red_c[2*k+1];
            p1 = red_s[2*k+1] ^ red_c[2*k+1];
            c1 = g0 | (p0 & cy);
            prod_o[2*k]   = p0 ^ cy;
            prod_o[2*k+1] = p1 ^ c1;
            cy = g1 | (p1 & g0) | (p1 & p0 & cy);
        end
    end
endmodule

// File: rtl/pairsel_mult.sv
module pairsel_mult #(
    parameter int W       = pairsel_pkg::DEF_WIDTH,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic [PW-1:0] prod;
    } out_t;

    logic [W-1:0]          run_sum;
    logic [W:1]            run_carry;
    logic [W-1:0][PW-1:0]  rows;
    logic [PW-1:0]         diag;
    logic [PW-1:0]         prod_comb;

    pairsel_sumchain #(.W(W)) u_chain (
        .a_i     (a_i),
        .b_i     (b_i),
        .sum_o   (run_sum),
        .carry_o (run_carry)
    );

    pairsel_rowgen #(.W(W)) u_rows (
        .a_i     (a_i),
        .b_i     (b_i),
        .sum_i   (run_sum[W-2:0]),
        .carry_i (run_carry[W-1:1]),
        .rows_o  (rows),
        .diag_o  (diag)
    );

    pairsel_accum #(.W(W)) u_acc (
        .rows_i  (rows),
        .diag_i  (diag),
        .prod_o  (prod_comb)
    );

    if (REG_OUT) begin : g_reg
        out_t out_d, out_q;

        always_comb begin
            out_d      = out_q;
            out_d.prod = prod_comb;
            if (rst) out_d.prod = '0;
        end

        always_ff @(posedge clk) begin
            out_q <= out_d;
        end

        assign prod_o = out_q.prod;

        // R6: output is the product of the operands one edge earlier
        assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> prod_o == $past(PW'(a_i) * PW'(b_i)));

        // R7: synchronous reset clears the product
        assert_reset_clear_R7: assert property (@(posedge clk)
            rst |=> prod_o == '0);
    end else begin : g_comb
        assign prod_o = prod_comb;
    end

    // R2: shared running sum equals arithmetic sum of the operands
    assert_sum_chain_R2: assert property (@(posedge clk) disable iff (rst)
        {run_carry[W], run_sum} == (W+1)'(a_i) + (W+1)'(b_i));

    // R3: every row term matches a[j]*low(b) + b[j]*low(a)
    for (genvar j = 0; j < W; j++) begin : g_row_chk
        localparam logic [PW-1:0] LOWMASK = (PW'(1) << j) - PW'(1);
        assert_row_term_R3: assert property (@(posedge clk) disable iff (rst)
            rows[j] == (((a_i[j] ? (PW'(b_i) & LOWMASK) : PW'(0)) +
                         (b_i[j] ? (PW'(a_i) & LOWMASK) : PW'(0))) << j));
    end

    // R1: combinational product equals the reference multiply
    assert_product_R1: assert property (@(posedge clk) disable iff (rst)
        prod_comb == PW'(a_i) * PW'(b_i));

endmodule

// File: tb/sim_pairsel_mult.sv
`timescale 1ns/1ps
module sim_pairsel_mult;
    localparam int W  = 16;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic [PW-1:0] prod_o;

    int checks = 0;
    int errors = 0;

    logic [PW-1:0] exp_pend;
    bit            pend_valid = 1'b0;
    string         pend_tag;

    pairsel_mult #(.W(W), .REG_OUT(1'b1)) u0 (
        .clk    (clk),
        .rst    (rst),
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod_o)
    );

    always #5 clk = ~clk;

    function automatic logic [PW-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y);
        return PW'(x) * PW'(y);
    endfunction

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Pipelined step: check previous vector, then drive a new one
    task automatic step(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        @(negedge clk);
        if (pend_valid) check(pend_tag, prod_o, exp_pend);
        a_i = x;
        b_i = y;
        exp_pend = model(x, y);
        pend_tag = tag;
        pend_valid = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pend_valid) check(pend_tag, prod_o, exp_pend);
        pend_valid = 1'b0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb;
        void'($urandom(32'h1234_5678));

        // R7: reset holds output at zero with nonzero operands
        a_i = 16'h00FF; b_i = 16'h0F0F;
        repeat (3) @(negedge clk);
        check("R7 reset state", prod_o, '0);
        rst = 1'b0;

        // R8 worked example and all-ones
        step(16'd7, 16'd3, "R8 7x3");
        step(16'hFFFF, 16'hFFFF, "R8 all-ones");
        flush();

        // R4 row 0 only
        step(16'd1, 16'd1, "R4 1x1");
        step(16'd1, 16'hFFFF, "R4 1xFFFF");
        step(16'hFFFF, 16'd1, "R4 FFFFx1");
        step(16'd0, 16'hFFFF, "R4 0xFFFF");
        step(16'd1, 16'd0, "R4 1x0");

        // R2 carry-heavy patterns
        step(16'h5555, 16'hAAAA, "R2 alt 5555xAAAA");
        step(16'hAAAA, 16'hAAAA, "R2 alt AAAAxAAAA");
        step(16'h5555, 16'h5555, "R2 alt 5555x5555");
        step(16'h7FFF, 16'h0001, "R2 7FFFx1");
        step(16'h8000, 16'h8000, "R2 8000x8000");

        // R3 single-bit selections per row
        for (int j = 0; j < W; j++) begin
            step(16'(1) << j, 16'hFFFF, "R3 a one-hot");
            step(16'hFFFF, 16'(1) << j, "R3 b one-hot");
            step((16'(1) << j) | 16'h0055, (16'(1) << j) | 16'h0033, "R3 both set");
        end
        flush();

        // R6: output unchanged before the edge, updated after it
        @(negedge clk);
        a_i = 16'd100; b_i = 16'd200;
        @(negedge clk);
        check("R6 after edge", prod_o, model(16'd100, 16'd200));
        a_i = 16'd3; b_i = 16'd9;
        #2;
        check("R6 before edge holds", prod_o, model(16'd100, 16'd200));
        @(negedge clk);
        check("R6 next edge", prod_o, 32'd27);

        // R7: mid-run reset
        @(negedge clk);
        rst = 1'b1; a_i = 16'hFFFF; b_i = 16'hFFFF;
        @(negedge clk);
        check("R7 mid-run reset", prod_o, '0);
        rst = 1'b0;

        // R1 exhaustive over 8-bit operands
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                step(16'(x), 16'(y), "R1 exhaustive 8-bit");
            end
        end

        // R5 symmetry and R1 random 16-bit
        for (int n = 0; n < 2000; n++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            step(ra, rb, "R1 random");
            step(rb, ra, "R5 swapped");
        end
        step(16'hFFFF, 16'h0000, "R5 FFFFx0");
        step(16'h0000, 16'hFFFF, "R5 0xFFFF");
        flush();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule